// File: doc/BRIEF.md
# Serial Port Register Front End with Delayed Interrupts

This block is the byte-wide register face of a classic serial port. It sits on a simple memory-mapped bus and decodes eight byte registers at offsets 0 to 7. Software uses them to read received bytes, send bytes, enable interrupts, program line and modem control, and poll status. Received bytes come from a valid/ready source. Transmitted bytes leave on a valid strobe toward a sink that is always ready. Bit-level shifting, baud generation, FIFOs and divisor storage are not part of this block.

One interrupt line is driven. A byte that arrives while the receive interrupt is enabled posts it at once. The other receive and transmit interrupt causes each start a per-channel delay timer of `DELAY_CYC` clock cycles. When a timer runs out, it posts its interrupt only if its enable bit is still set. Arming a timer that is already running restarts its count.

The receive stream is popped only by a data read at offset 0 with the divisor-latch mode off. `rx_ready` is high in that bus cycle, and the source must hold `rx_valid` and `rx_data` steady until it sees `rx_ready`. A byte counts as still waiting after a pop only if the source presents it in the next cycle. The transmit side has no back-pressure: `tx_valid` lasts one cycle and the sink must take `tx_data` in that cycle.

Bus timing works as follows. `bus_rdata` and `bus_err` are combinational in the cycle `bus_req` is high. All side effects take place at the next rising clock edge.

Top module: `uart_regfront`

## Requirements
- R1: An access with `bus_addr` of 8 or more raises `bus_err` in that cycle. It returns 0 on `bus_rdata`, sends no byte and changes no state.
- R2: While line-control bit 7 is set, offsets 0 and 1 address the divisor latch. Reads there return 0 and do not pop the receive stream. Writes there send nothing and leave the enable register unchanged.
- R3: A read of offset 2 returns 0x00 while either interrupt status bit is set, and 0x01 otherwise.
- R4: A read of offset 5 returns bit 0 = 1 exactly when `rx_valid` is high, with bits 5 and 6 always 1 and all other bits 0 (0x60 or 0x61).
- R5: A data read at offset 0 returns `rx_data` when `rx_valid` is high and 0 otherwise. It pops the byte, clears the receive status bit and drops `irq`. If the receive enable is set and `rx_valid` is high in the following cycle, the receive timer is re-armed; otherwise it is not.
- R6: A data write at offset 0 drives `tx_valid` with `tx_data` = written byte for that cycle, clears the transmit status bit and drops `irq`. It re-arms the transmit timer only if the transmit enable is set.
- R7: The enable register is at offset 1: bit 0 enables receive data and bit 1 enables transmit-empty. Writing it with bit 1 set arms the transmit timer. Writing it with bit 1 clear cancels that timer, clears the transmit status and drops `irq` if that status was set. Bit 0 behaves the same for the receive timer, except that it arms only when `rx_valid` is high.
- R8: A timer armed at clock edge N posts `irq` and sets its status bit at edge N+`DELAY_CYC`, provided its enable bit is still set. Re-arming restarts the count from the new edge.
- R9: A rising `rx_valid` while the receive enable is set sets the receive status and asserts `irq` at the next clock edge. With the enable clear it has no effect on `irq`.
- R10: Writing 0x1A (loopback bit 0x10 OR 0x0A) to offset 4 stores 0x9A, and any other value written there is ignored. Offset 4 reads back the stored value. Offsets 6 and 7 read 0, and writes to offsets 2 and 7 are ignored.
- R11: After reset the enable, line-control and modem-control registers read 0, both timers are idle and `irq` is low.
- R12: Offset 3 (line control) and offset 1 (enable, with divisor mode off) read back the last byte written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the request cycle |
| bus_err | output | 1 | Out-of-range access in this cycle |
| rx_valid | input | 1 | Receive source has a byte |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Byte is consumed at this clock edge |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Interrupt line |

## Verification
The bench builds the block with `DELAY_CYC` = 5 and `ADDR_W` = 8. The short delay lets the bench sample the cycle just before and just after each timer expiry. It also lets the bench re-arm a running transmit timer one cycle after arming it and see the expiry move by exactly one cycle. The 8-bit offset lets the bench drive offsets 8 and 0x20 to reach the out-of-range error path. The same delay keeps waits of twice the delay short, which is how the bench shows that cancelled and unarmed timers never fire.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
  localparam int NUM_REGS = 8;

  typedef enum logic [2:0] {
    OFS_DATA  = 3'd0,
    OFS_IEN   = 3'd1,
    OFS_IID   = 3'd2,
    OFS_LCTL  = 3'd3,
    OFS_MCTL  = 3'd4,
    OFS_LSTAT = 3'd5,
    OFS_MSTAT = 3'd6,
    OFS_SCR   = 3'd7
  } ofs_e;

  // channel index equals its enable bit position
  localparam int CH_RX  = 0;
  localparam int CH_TX  = 1;
  localparam int NUM_CH = 2;

  localparam int LCTL_DL_BIT    = 7;
  localparam int LSTAT_DR_BIT   = 0;
  localparam int LSTAT_THE_BIT  = 5;
  localparam int LSTAT_TEMT_BIT = 6;

  localparam logic [7:0] MCTL_LOOP   = 8'h10;
  localparam logic [7:0] MCTL_MATCH  = MCTL_LOOP | 8'h0A;
  localparam logic [7:0] MCTL_STORED = 8'h9A;
endpackage

// File: rtl/uart_rf_decode.sv
module uart_rf_decode
  import uart_rf_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                req,
  input  logic                we,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                dl_mode,
  output logic                bad,
  output logic [NUM_REGS-1:0] rd_sel,
  output logic [NUM_REGS-1:0] wr_sel
);
  logic       in_range;
  logic [2:0] ofs;

  assign in_range = addr < ADDR_W'(NUM_REGS);
  assign ofs      = addr[2:0];
  assign bad      = req && !in_range;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
    localparam bit IS_LATCH = (g == int'(OFS_DATA)) || (g == int'(OFS_IEN));
    logic hit;
    assign hit       = req && in_range && (ofs == 3'(g)) && !(IS_LATCH && dl_mode);
    assign rd_sel[g] = hit && !we;
    assign wr_sel[g] = hit && we;
  end
endmodule

// File: rtl/uart_rf_timer.sv
module uart_rf_timer #(
  parameter int DELAY = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic cancel,
  output logic fire
);
  localparam int CW = (DELAY < 2) ? 1 : $clog2(DELAY + 1);

  logic [CW-1:0] cnt;
  logic          run;

  assign fire = run && (cnt == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (arm) begin
      run <= 1'b1;
      cnt <= CW'(DELAY);
    end else if (cancel || fire) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (run) begin
      cnt <= cnt - CW'(1);
    end
  end
endmodule

// File: rtl/uart_rf_irq.sv
module uart_rf_irq
  import uart_rf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] fire,
  input  logic [NUM_CH-1:0] en,
  input  logic              arrive,
  input  logic              pop,
  input  logic              send,
  input  logic              ien_wr,
  input  logic [NUM_CH-1:0] ien_new,
  output logic [NUM_CH-1:0] st,
  output logic              irq
);
  logic [NUM_CH-1:0] st_d;
  logic              irq_d;

  always_comb begin
    st_d  = st;
    irq_d = irq;
    // timer expiries and arrivals post first
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (fire[ch] && en[ch]) begin
        st_d[ch] = 1'b1;
        irq_d    = 1'b1;
      end
    end
    if (arrive && en[CH_RX]) begin
      st_d[CH_RX] = 1'b1;
      irq_d       = 1'b1;
    end
    // bus side effects take precedence
    if (pop) begin
      st_d[CH_RX] = 1'b0;
      irq_d       = 1'b0;
    end
    if (send) begin
      st_d[CH_TX] = 1'b0;
      irq_d       = 1'b0;
    end
    if (ien_wr) begin
      for (int ch = 0; ch < NUM_CH; ch++) begin
        if (!ien_new[ch]) begin
          if (st_d[ch]) irq_d = 1'b0;
          st_d[ch] = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= '0;
      irq <= 1'b0;
    end else begin
      st  <= st_d;
      irq <= irq_d;
    end
  end
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_rf_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DELAY_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              bus_err,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              irq
);
  logic [7:0]          ien_q, lctl_q, mctl_q;
  logic [NUM_REGS-1:0] rd_sel, wr_sel;
  logic [NUM_CH-1:0]   arm, cancel, fire, st_q;
  logic                rxv_q, chk_q, arrive, pop, send, ien_wr;

  uart_rf_decode #(.ADDR_W(ADDR_W)) u_dec (
    .req     (bus_req),
    .we      (bus_we),
    .addr    (bus_addr),
    .dl_mode (lctl_q[LCTL_DL_BIT]),
    .bad     (bus_err),
    .rd_sel  (rd_sel),
    .wr_sel  (wr_sel)
  );

  assign pop      = rd_sel[OFS_DATA];
  assign send     = wr_sel[OFS_DATA];
  assign ien_wr   = wr_sel[OFS_IEN];
  assign rx_ready = pop;
  assign tx_valid = send;
  assign tx_data  = bus_wdata;
  assign arrive   = rx_valid && !rxv_q;

  // read multiplexer
  always_comb begin
    bus_rdata = 8'h00;
    if (rd_sel[OFS_DATA])  bus_rdata = rx_valid ? rx_data : 8'h00;
    if (rd_sel[OFS_IEN])   bus_rdata = ien_q;
    if (rd_sel[OFS_IID])   bus_rdata = (st_q != '0) ? 8'h00 : 8'h01;
    if (rd_sel[OFS_LCTL])  bus_rdata = lctl_q;
    if (rd_sel[OFS_MCTL])  bus_rdata = mctl_q;
    if (rd_sel[OFS_LSTAT]) begin
      bus_rdata[LSTAT_DR_BIT]   = rx_valid;
      bus_rdata[LSTAT_THE_BIT]  = 1'b1;
      bus_rdata[LSTAT_TEMT_BIT] = 1'b1;
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= '0;
      lctl_q <= '0;
      mctl_q <= '0;
      rxv_q  <= 1'b0;
      chk_q  <= 1'b0;
    end else begin
      rxv_q <= rx_valid;
      chk_q <= pop;
      if (ien_wr) ien_q <= bus_wdata;
      if (wr_sel[OFS_LCTL]) lctl_q <= bus_wdata;
      if (wr_sel[OFS_MCTL] && (bus_wdata == MCTL_MATCH)) mctl_q <= MCTL_STORED;
    end
  end

  // timer control
  always_comb begin
    arm[CH_TX]    = (send && ien_q[CH_TX]) || (ien_wr && bus_wdata[CH_TX]);
    cancel[CH_TX] = ien_wr && !bus_wdata[CH_TX];
    arm[CH_RX]    = ien_wr ? (bus_wdata[CH_RX] && rx_valid)
                           : (chk_q && rx_valid && ien_q[CH_RX]);
    cancel[CH_RX] = ien_wr && !bus_wdata[CH_RX];
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_tmr
    uart_rf_timer #(.DELAY(DELAY_CYC)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm    (arm[ch]),
      .cancel (cancel[ch]),
      .fire   (fire[ch])
    );
  end

  uart_rf_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (fire),
    .en      (ien_q[NUM_CH-1:0]),
    .arrive  (arrive),
    .pop     (pop),
    .send    (send),
    .ien_wr  (ien_wr),
    .ien_new (bus_wdata[NUM_CH-1:0]),
    .st      (st_q),
    .irq     (irq)
  );
endmodule

// File: rtl/uart_regfront_chk.sv
module uart_regfront_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              bus_err,
  input logic              rx_ready,
  input logic              tx_valid,
  input logic              irq,
  input logic [7:0]        lctl,
  input logic [7:0]        mctl,
  input logic [1:0]        st
);
  AST_ERR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_addr >= ADDR_W'(8)) |-> (bus_err && bus_rdata == 8'h00 && !tx_valid && !rx_ready)); // R1
  AST_DL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && lctl[7] && bus_addr < ADDR_W'(2)) |-> (!tx_valid && !rx_ready && bus_rdata == 8'h00)); // R2
  AST_IID_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && bus_req && !bus_we && bus_addr == ADDR_W'(2)) |-> (bus_rdata == 8'h00)); // R3
  AST_LSTAT_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && bus_addr == ADDR_W'(5)) |-> (bus_rdata[6:5] == 2'b11)); // R4
  AST_POP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |=> !irq); // R5
  AST_SEND_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |=> !irq); // R6
  AST_TX_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_addr == ADDR_W'(1) && !lctl[7] && !bus_wdata[1]) |=> !st[1]); // R7
  AST_MCTL_VAL: assert property (@(posedge clk) disable iff (!rst_n)
    (mctl == 8'h00 || mctl == 8'h9A)); // R10
endmodule

bind uart_regfront uart_regfront_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_req   (bus_req),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .bus_err   (bus_err),
  .rx_ready  (rx_ready),
  .tx_valid  (tx_valid),
  .irq       (irq),
  .lctl      (lctl_q),
  .mctl      (mctl_q),
  .st        (st_q)
);

// File: tb/tb_uart_regfront.sv
`timescale 1ns/1ps
module tb_uart_regfront;
  localparam int AW = 8;
  localparam int D  = 5;
  localparam int NV = 28;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_req = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic          bus_err;
  logic          rx_valid = 1'b0;
  logic [7:0]    rx_data = '0;
  logic          rx_ready, tx_valid, irq;
  logic [7:0]    tx_data;

  int nchk = 0;
  int nfail = 0;

  always #4 clk = ~clk;

  uart_regfront #(.ADDR_W(AW), .DELAY_CYC(D)) dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
  );

  // {we, addr, wdata, expected rdata, expected err, requirement number}
  localparam logic [29:0] VEC [NV] = '{
    {1'b0, 8'h03, 8'h00, 8'h00, 1'b0, 4'd11}, // R11 line control reset
    {1'b0, 8'h01, 8'h00, 8'h00, 1'b0, 4'd11}, // R11 enable reset
    {1'b0, 8'h04, 8'h00, 8'h00, 1'b0, 4'd11}, // R11 modem control reset
    {1'b1, 8'h03, 8'h03, 8'h00, 1'b0, 4'd12}, // R12
    {1'b0, 8'h03, 8'h00, 8'h03, 1'b0, 4'd12}, // R12
    {1'b1, 8'h04, 8'h55, 8'h00, 1'b0, 4'd10}, // R10 ignored value
    {1'b0, 8'h04, 8'h00, 8'h00, 1'b0, 4'd10}, // R10
    {1'b1, 8'h04, 8'h1A, 8'h00, 1'b0, 4'd10}, // R10 loopback pattern
    {1'b0, 8'h04, 8'h00, 8'h9A, 1'b0, 4'd10}, // R10
    {1'b0, 8'h06, 8'h00, 8'h00, 1'b0, 4'd10}, // R10 modem status
    {1'b1, 8'h07, 8'hFF, 8'h00, 1'b0, 4'd10}, // R10 scratch write
    {1'b0, 8'h07, 8'h00, 8'h00, 1'b0, 4'd10}, // R10 scratch read
    {1'b0, 8'h05, 8'h00, 8'h60, 1'b0, 4'd4},  // R4 no data
    {1'b0, 8'h02, 8'h00, 8'h01, 1'b0, 4'd3},  // R3 none pending
    {1'b0, 8'h08, 8'h00, 8'h00, 1'b1, 4'd1},  // R1
    {1'b1, 8'h20, 8'hAA, 8'h00, 1'b1, 4'd1},  // R1
    {1'b1, 8'h01, 8'h01, 8'h00, 1'b0, 4'd12}, // R12
    {1'b0, 8'h01, 8'h00, 8'h01, 1'b0, 4'd12}, // R12
    {1'b1, 8'h03, 8'h83, 8'h00, 1'b0, 4'd2},  // R2 divisor mode on
    {1'b0, 8'h03, 8'h00, 8'h83, 1'b0, 4'd12}, // R12
    {1'b1, 8'h01, 8'h00, 8'h00, 1'b0, 4'd2},  // R2 latch write
    {1'b0, 8'h01, 8'h00, 8'h00, 1'b0, 4'd2},  // R2 latch read
    {1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 4'd2},  // R2 latch read
    {1'b1, 8'h03, 8'h03, 8'h00, 1'b0, 4'd2},  // R2 divisor mode off
    {1'b0, 8'h01, 8'h00, 8'h01, 1'b0, 4'd2},  // R2 enable untouched
    {1'b1, 8'h01, 8'h00, 8'h00, 1'b0, 4'd7},  // R7 clear enables
    {1'b1, 8'h02, 8'hC7, 8'h00, 1'b0, 4'd10}, // R10 FIFO control ignored
    {1'b0, 8'h02, 8'h00, 8'h01, 1'b0, 4'd10}  // R10
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic we, input logic [AW-1:0] a, input logic [7:0] d,
                     output logic [7:0] rd, output logic e,
                     output logic txv, output logic [7:0] txd, output logic rxr);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    #2;
    rd = bus_rdata; e = bus_err; txv = tx_valid; txd = tx_data; rxr = rx_ready;
    @(posedge clk);
    #1;
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    logic [7:0] r, t; logic e, v, q;
    acc(1'b1, a, d, r, e, v, t, q);
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] r, t; logic e, v, q;
    acc(1'b0, a, 8'h00, r, e, v, t, q);
    chk(tag, r, exp);
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] r, t; logic e, v, q;

    // reset state, R11
    repeat (3) @(posedge clk);
    #1;
    chk("R11 irq after reset", {7'd0, irq}, 8'h00);
    chk("R11 tx_valid after reset", {7'd0, tx_valid}, 8'h00);
    chk("R11 rx_ready after reset", {7'd0, rx_ready}, 8'h00);
    @(negedge clk) rst_n = 1'b1;

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [29:0] vv;
      vv = VEC[i];
      acc(vv[29], vv[28:21], vv[20:13], r, e, v, t, q);
      nchk++;
      if (r !== vv[12:5] || e !== vv[4]) begin
        nfail++;
        $display("FAIL R%0d vector %0d actual=%02h/%b expected=%02h/%b",
                 vv[3:0], i, r, e, vv[12:5], vv[4]);
      end
    end

    // R2 and R9: arrival with receive enable clear, latch read does not pop
    @(negedge clk);
    rx_data = 8'h77; rx_valid = 1'b1;
    @(posedge clk); #1;
    chk("R9 arrival with enable clear", {7'd0, irq}, 8'h00);
    wr(8'h03, 8'h80);
    acc(1'b0, 8'h00, 8'h00, r, e, v, t, q);
    chk("R2 latch read data", r, 8'h00);
    chk("R2 latch read no pop", {7'd0, q}, 8'h00);
    wr(8'h03, 8'h03);
    acc(1'b0, 8'h00, 8'h00, r, e, v, t, q);
    chk("R5 data read", r, 8'h77);
    chk("R5 pop strobe", {7'd0, q}, 8'h01);
    rx_valid = 1'b0;
    wait_cyc(2);

    // R7: receive enable without waiting data does not arm
    wr(8'h01, 8'h01);
    wait_cyc(2 * D);
    chk("R7 no arm without data", {7'd0, irq}, 8'h00);

    // R9: arrival with enable set posts at once
    @(negedge clk);
    rx_data = 8'h41; rx_valid = 1'b1;
    @(posedge clk); #1;
    chk("R9 immediate receive interrupt", {7'd0, irq}, 8'h01);
    rd_chk(8'h02, 8'h00, "R3 pending");
    rd_chk(8'h05, 8'h61, "R4 data ready");
    acc(1'b0, 8'h00, 8'h00, r, e, v, t, q);
    rx_data = 8'h42;
    chk("R5 data read byte", r, 8'h41);
    chk("R5 irq dropped", {7'd0, irq}, 8'h00);
    wait_cyc(D);
    chk("R8 receive re-arm not yet", {7'd0, irq}, 8'h00);
    wait_cyc(1);
    chk("R8 receive re-arm expiry", {7'd0, irq}, 8'h01);
    acc(1'b0, 8'h00, 8'h00, r, e, v, t, q);
    rx_valid = 1'b0;
    chk("R5 second byte", r, 8'h42);
    wait_cyc(2 * D);
    chk("R5 no re-arm when empty", {7'd0, irq}, 8'h00);

    // R7 and R8: transmit enable arms the timer
    wr(8'h01, 8'h02);
    wait_cyc(D - 1);
    chk("R8 transmit not yet", {7'd0, irq}, 8'h00);
    wait_cyc(1);
    chk("R7 transmit interrupt", {7'd0, irq}, 8'h01);
    rd_chk(8'h02, 8'h00, "R3 transmit pending");

    // R6: data write sends and drops irq
    acc(1'b1, 8'h00, 8'h5A, r, e, v, t, q);
    chk("R6 tx_valid", {7'd0, v}, 8'h01);
    chk("R6 tx_data", t, 8'h5A);
    chk("R6 irq dropped", {7'd0, irq}, 8'h00);

    // R8: re-arm one cycle later restarts the count
    wr(8'h01, 8'h02);
    wait_cyc(D - 1);
    chk("R8 restart delays expiry", {7'd0, irq}, 8'h00);
    wait_cyc(1);
    chk("R8 restarted expiry", {7'd0, irq}, 8'h01);

    // R7: clearing transmit enable drops irq and status
    wr(8'h01, 8'h00);
    chk("R7 cancel drops irq", {7'd0, irq}, 8'h00);
    rd_chk(8'h02, 8'h01, "R7 status cleared");

    // R6: data write with enable clear does not arm
    acc(1'b1, 8'h00, 8'h33, r, e, v, t, q);
    chk("R6 send with enable clear", {7'd0, v}, 8'h01);
    wait_cyc(2 * D);
    chk("R6 no arm when disabled", {7'd0, irq}, 8'h00);

    // R1: out-of-range write sends nothing
    acc(1'b1, 8'h08, 8'h55, r, e, v, t, q);
    chk("R1 err flag", {7'd0, e}, 8'h01);
    chk("R1 no transmit", {7'd0, v}, 8'h00);
    rd_chk(8'h01, 8'h00, "R1 enable unchanged");

    summary();
    $finish;
  end
endmodule